// File: doc/BRIEF.md
# Strap-Configured Expansion ROM Controller

This block runs a slow external ROM or flash device over a single 8-bit bidirectional bus. Address bytes reach the device through external 8-bit latches. Right after reset it waits a fixed number of clocks. It then captures four strap bits from the bus, which resistors pull to their levels. Three of those bits select the memory size, in power-of-two steps from 16 KB to 1 MB, or report that no memory is fitted. The fourth bit selects slow or fast cycle timing.

After configuration, a host-side request port accepts one byte access at a time. The offset is cut down to the fitted size. The block strobes the address latches low byte first, then middle, then high. It skips the high latch when the device needs no more than 16 address lines. It then holds the read or write strobe for a fixed count of clocks and returns one response pulse with the bus released. A registered enable output switches the flash programming supply when the host asks for it.

Top module: `xrom_ctrl`

## Requirements
- R1: While STRAP_DELAY clock edges have not yet passed since reset release, req_ready and bus_oe stay low. The strap is captured from bus_in[3:0] at that edge and is never sampled again until the next reset, so later bus activity leaves size_mask unchanged.
- R2: With strap bits 3..1 equal to a code from 0 to 6, size_mask equals (16384 × 2^code) − 1 and rom_present is high. For example, code 3 gives 0x1FFFF.
- R3: With strap code 7, rom_present is low and size_mask is zero. Every request is answered with resp_err high and no latch, read or write strobe is raised.
- R4: The offset sent to the latches is req_addr AND size_mask, so an address above the fitted size aliases into it.
- R5: An access raises lat_lo, then lat_mid, then lat_hi, one clock each with the matching address byte on bus_out. lat_hi is skipped when the code is 2 or less (64 KB or smaller). At most one strobe of any kind is high in a cycle.
- R6: mem_rd stays high for FAST_CLKS clocks when strap bit 0 is 1 and for SLOW_CLKS clocks when it is 0. resp_rdata is the bus_in value seen in the last cycle of mem_rd.
- R7: A write holds mem_wr for the same speed-selected count, with bus_oe high and bus_out equal to the write byte in every one of those cycles. mem_rd stays low during a write.
- R8: The bus is released (bus_oe low) while mem_rd is high, in the response cycle and whenever the block is idle.
- R9: Once configured with memory present, vpp_en equals prog_req delayed by one clock. It is low during reset and whenever no memory is fitted.
- R10: req_ready is high only when idle. Each accepted request yields exactly one cycle of resp_valid, after which req_ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the expansion space |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Block idle and able to accept a request |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Request refused (no memory fitted) |
| resp_rdata | output | 8 | Byte read from the device |
| prog_req | input | 1 | Host request for the programming supply |
| vpp_en | output | 1 | Programming supply enable |
| bus_in | input | 8 | Value seen on the shared memory bus |
| bus_out | output | 8 | Value driven onto the shared memory bus |
| bus_oe | output | 1 | Bus output enable |
| lat_lo | output | 1 | Strobe for the low address latch |
| lat_mid | output | 1 | Strobe for the middle address latch |
| lat_hi | output | 1 | Strobe for the high address latch |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| size_mask | output | ADDR_W | Offset mask for the fitted size, zero if none |
| rom_present | output | 1 | External memory fitted |

## Verification
The configuration is fixed once per reset, so the hardest case to reach is how size and speed interact with the access sequence. The bench reaches it by resetting again with a new strap value driven on the bus model for each scenario. Each reset is followed by reads and writes whose addresses lie above the fitted size. Across those resets the bench covers the two-latch and three-latch paths, both strobe widths and the no-memory refusal. A bench-side latch model builds the device address from the observed latch strobes, so the aliased offset and the read data are checked through the bus itself.

// File: rtl/xrom_pkg.sv
package xrom_pkg;

  typedef enum logic [2:0] {
    S_STRAP,
    S_IDLE,
    S_LATCH,
    S_DATA,
    S_RESP
  } seq_state_e;

  localparam logic [2:0] CODE_ABSENT = 3'b111;

  // Offset mask for a size code; the smallest size is 2**base_log2 bytes.
  function automatic logic [31:0] span_mask(input logic [2:0] code, input int base_log2);
    if (code == CODE_ABSENT) return 32'd0;
    return (32'd1 << (base_log2 + int'(code))) - 32'd1;
  endfunction

  // True when the offset needs more than 16 bits, i.e. a third latch byte.
  function automatic logic third_latch(input logic [2:0] code, input int base_log2);
    return (code != CODE_ABSENT) && ((base_log2 + int'(code)) > 16);
  endfunction

  // Number of clocks the data strobe is held.
  function automatic int strobe_clks(input logic fast, input int slow_n, input int fast_n);
    return fast ? fast_n : slow_n;
  endfunction

endpackage

// File: rtl/xrom_strap.sv
module xrom_strap #(
  parameter int DELAY = 4,
  parameter int STRAP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [STRAP_W-1:0] strap_q,
  output logic               strap_done
);
  localparam int CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;

  logic [CNT_W-1:0] wait_cnt;
  logic             capture_now;

  assign capture_now = !strap_done && (wait_cnt == CNT_W'(DELAY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt   <= '0;
      strap_q    <= '0;
      strap_done <= 1'b0;
    end else if (capture_now) begin
      strap_q    <= strap_in;
      strap_done <= 1'b1;
    end else if (!strap_done) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R1: once captured, the strap never changes until the next reset
  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_done) |-> $stable(strap_q));

endmodule

// File: rtl/xrom_seq.sv
module xrom_seq
  import xrom_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BASE_LOG2 = 14,
  parameter int SLOW_CLKS = 6,
  parameter int FAST_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ready,
  input  logic [2:0]        size_code,
  input  logic              fast,
  input  logic [7:0]        bus_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [7:0]        resp_rdata,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  output logic              lat_lo,
  output logic              lat_mid,
  output logic              lat_hi,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] size_mask,
  output logic              present
);
  localparam int MAX_H = (SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS;
  localparam int CNT_W = $clog2(MAX_H + 1);
  localparam int EXT_W = 24;

  seq_state_e        state;
  logic [1:0]        phase;
  logic [CNT_W-1:0]  dcnt;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [7:0]        wd_q;
  logic [7:0]        rdata_q;
  logic              err_q;

  // named internal events
  logic [31:0]       mask_full;
  logic [1:0]        last_phase;
  logic [CNT_W-1:0]  hold_m1;
  logic [EXT_W-1:0]  addr_ext;
  logic              in_latch;
  logic              in_data;
  logic              accept;
  logic              latch_last;
  logic              data_last;

  assign mask_full  = span_mask(size_code, BASE_LOG2);
  assign size_mask  = cfg_ready ? mask_full[ADDR_W-1:0] : '0;
  assign present    = (size_code != CODE_ABSENT);
  assign last_phase = third_latch(size_code, BASE_LOG2) ? 2'd2 : 2'd1;
  assign hold_m1    = CNT_W'(strobe_clks(fast, SLOW_CLKS, FAST_CLKS) - 1);
  assign addr_ext   = EXT_W'(addr_q);

  assign in_latch   = (state == S_LATCH);
  assign in_data    = (state == S_DATA);
  assign accept     = (state == S_IDLE) && req_valid;
  assign latch_last = in_latch && (phase == last_phase);
  assign data_last  = in_data && (dcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_STRAP;
      phase   <= '0;
      dcnt    <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state)
        S_STRAP: if (cfg_ready) state <= S_IDLE;
        S_IDLE: begin
          if (accept) begin
            addr_q <= req_addr & size_mask;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            phase  <= '0;
            if (!present) begin
              err_q <= 1'b1;
              state <= S_RESP;
            end else begin
              err_q <= 1'b0;
              state <= S_LATCH;
            end
          end
        end
        S_LATCH: begin
          if (latch_last) begin
            dcnt  <= hold_m1;
            state <= S_DATA;
          end else begin
            phase <= phase + 2'd1;
          end
        end
        S_DATA: begin
          if (data_last) begin
            if (!wr_q) rdata_q <= bus_in;
            state <= S_RESP;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign resp_valid = (state == S_RESP);
  assign resp_err   = err_q;
  assign resp_rdata = rdata_q;

  assign lat_lo  = in_latch && (phase == 2'd0);
  assign lat_mid = in_latch && (phase == 2'd1);
  assign lat_hi  = in_latch && (phase == 2'd2);
  assign mem_rd  = in_data && !wr_q;
  assign mem_wr  = in_data && wr_q;
  assign bus_oe  = in_latch || mem_wr;

  always_comb begin
    bus_out = wd_q;
    if (in_latch) begin
      case (phase)
        2'd0:    bus_out = addr_ext[7:0];
        2'd1:    bus_out = addr_ext[15:8];
        default: bus_out = addr_ext[23:16];
      endcase
    end
  end

  // R5: strobes are exclusive
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lat_lo, lat_mid, lat_hi, mem_rd, mem_wr}));
  // R5: latch order low -> mid -> high
  assert_mid_after_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lat_mid |-> $past(lat_lo));
  assert_hi_after_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lat_hi |-> $past(lat_mid));
  // R3: nothing strobed when memory is absent
  assert_absent_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && !present) |-> !(lat_lo || mem_rd || mem_wr));
  // R7: write data is driven while writing
  assert_write_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (bus_oe && $stable(bus_out)) || $rose(mem_wr));
  // R8: bus released for reads and response
  assert_read_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || resp_valid || req_ready) |-> !bus_oe);
  // R10: one-cycle response then ready
  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready));

endmodule

// File: rtl/xrom_ctrl.sv
module xrom_ctrl
  import xrom_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BASE_LOG2 = 14,
  parameter int SLOW_CLKS = 6,
  parameter int FAST_CLKS = 2,
  parameter int STRAP_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [7:0]        resp_rdata,
  input  logic              prog_req,
  output logic              vpp_en,
  input  logic [7:0]        bus_in,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  output logic              lat_lo,
  output logic              lat_mid,
  output logic              lat_hi,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] size_mask,
  output logic              rom_present
);
  localparam int MAX_H = (SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS;
  localparam int RUN_W = $clog2(MAX_H + 2);

  logic [3:0] strap_q;
  logic       strap_done;
  logic       present_raw;

  xrom_strap #(.DELAY(STRAP_DELAY), .STRAP_W(4)) u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_in   (bus_in[3:0]),
    .strap_q    (strap_q),
    .strap_done (strap_done)
  );

  xrom_seq #(
    .ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2),
    .SLOW_CLKS(SLOW_CLKS), .FAST_CLKS(FAST_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ready  (strap_done),
    .size_code  (strap_q[3:1]),
    .fast       (strap_q[0]),
    .bus_in     (bus_in),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .lat_lo     (lat_lo),
    .lat_mid    (lat_mid),
    .lat_hi     (lat_hi),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .size_mask  (size_mask),
    .present    (present_raw)
  );

  assign rom_present = strap_done && present_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) vpp_en <= 1'b0;
    else        vpp_en <= prog_req && rom_present;
  end

  // checker state: length of the current data strobe
  logic             any_strobe;
  logic [RUN_W-1:0] run_len;
  assign any_strobe = mem_rd || mem_wr;
  always_ff @(posedge clk) begin
    if (!rst_n)          run_len <= '0;
    else if (any_strobe) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  // R6: strobe width follows the speed strap
  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strobe) |-> (run_len == RUN_W'(strap_q[0] ? FAST_CLKS : SLOW_CLKS)));
  // R1: no request accepted before strap capture
  assert_wait_strap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_done |-> (!req_ready && !bus_oe));
  // R9: supply enable tracks the request one clock later
  assert_vpp_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rom_present)) |-> (vpp_en == $past(prog_req)));
  assert_vpp_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && !rom_present) |-> !vpp_en);

endmodule

// File: tb/test_xrom_ctrl.sv
module test_xrom_ctrl;
  localparam int ADDR_W = 20;
  localparam int SLOW_N = 6;
  localparam int FAST_N = 2;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, resp_valid, resp_err;
  logic [7:0] resp_rdata;
  logic prog_req = 1'b0, vpp_en;
  logic [7:0] bus_in, bus_out;
  logic bus_oe, lat_lo, lat_mid, lat_hi, mem_rd, mem_wr;
  logic [ADDR_W-1:0] size_mask;
  logic rom_present;

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench-side bus model
  logic       strap_drive = 1'b1;
  logic [7:0] strap_val = 8'h00;
  logic [7:0] ll = 0, lm = 0, lh = 0;
  int         cur_code = 0;

  function automatic int exp_mask(input int code);
    if (code == 7) return 0;
    return 16384 * (1 << code) - 1;
  endfunction

  function automatic logic [7:0] rom_pat(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'hA};
  endfunction

  logic [19:0] dev_addr;
  assign dev_addr = {lh[3:0], lm, ll} & 20'(exp_mask(cur_code));
  assign bus_in = strap_drive ? strap_val : (mem_rd ? rom_pat(dev_addr) : 8'h00);

  xrom_ctrl #(.ADDR_W(ADDR_W), .SLOW_CLKS(SLOW_N), .FAST_CLKS(FAST_N),
              .STRAP_DELAY(DLY)) i_xrom_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .prog_req(prog_req), .vpp_en(vpp_en), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .lat_lo(lat_lo), .lat_mid(lat_mid), .lat_hi(lat_hi),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .size_mask(size_mask),
    .rom_present(rom_present)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reset with a strap byte; checks the wait window (R1) and the decode
  task automatic apply_reset(input int code, input logic fast);
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    prog_req = 1'b0;
    strap_drive = 1'b1;
    strap_val = {4'h0, 3'(code), fast};
    cur_code = code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DLY; i++) begin
      @(negedge clk);
      chk("R1", "ready during strap wait", 32'(req_ready), 0);
      chk("R1", "bus_oe during strap wait", 32'(bus_oe), 0);
    end
    strap_drive = 1'b0;
    @(negedge clk);
    chk("R1", "ready after strap", 32'(req_ready), 1);
  endtask

  // access results
  int         nlat, nrd, nwr, wr_bad, ready_busy, oe_resp, cycles;
  int         lat_id[3];
  logic [7:0] lat_byte[3];
  logic       got_err;
  logic [7:0] got_data;

  task automatic access(input logic wr, input logic [19:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    nlat = 0; nrd = 0; nwr = 0; wr_bad = 0; ready_busy = 0; oe_resp = 0;
    got_err = 0; got_data = 0;
    for (cycles = 0; cycles < 100; cycles++) begin
      if (lat_lo || lat_mid || lat_hi) begin
        if (nlat < 3) begin
          lat_id[nlat] = lat_lo ? 0 : (lat_mid ? 1 : 2);
          lat_byte[nlat] = bus_out;
        end
        nlat++;
        if (lat_lo) ll = bus_out;
        if (lat_mid) lm = bus_out;
        if (lat_hi) lh = bus_out;
      end
      if (mem_rd) nrd++;
      if (mem_wr) begin
        nwr++;
        if (!bus_oe || bus_out !== d) wr_bad++;
      end
      if (req_ready) ready_busy++;
      if (resp_valid) begin
        got_err = resp_err;
        got_data = resp_rdata;
        oe_resp = bus_oe;
        break;
      end
      @(negedge clk);
    end
    chk("R10", "response seen", 32'(cycles < 100), 1);
    chk("R10", "ready low while busy", 32'(ready_busy), 0);
    @(negedge clk);
    chk("R10", "single response pulse", 32'(resp_valid), 0);
    chk("R10", "ready after response", 32'(req_ready), 1);
    chk("R8", "bus released in response", 32'(oe_resp), 0);
    chk("R8", "bus released when idle", 32'(bus_oe), 0);
  endtask

  task automatic check_latches(input logic [19:0] a, input int code);
    logic [23:0] m;
    int n;
    m = 24'(a & 20'(exp_mask(code)));
    n = (code >= 3) ? 3 : 2;
    chk("R5", "latch count", 32'(nlat), 32'(n));
    for (int k = 0; k < n; k++) begin
      chk("R5", "latch order", 32'(lat_id[k]), 32'(k));
      chk("R4", "latch byte", 32'(lat_byte[k]), 32'(m[k*8 +: 8]));
    end
  endtask

  task automatic test_sizes;
    for (int c = 0; c < 7; c++) begin
      apply_reset(c, 1'b1);
      chk("R2", "size mask", 32'(size_mask), 32'(exp_mask(c)));
      chk("R2", "present", 32'(rom_present), 1);
    end
  endtask

  task automatic test_strap_frozen;
    apply_reset(3, 1'b1);
    chk("R2", "mask code 3", 32'(size_mask), 32'h1FFFF);
    strap_drive = 1'b1;
    strap_val = 8'h0E;
    repeat (5) @(negedge clk);
    strap_drive = 1'b0;
    chk("R1", "mask not resampled", 32'(size_mask), 32'h1FFFF);
    chk("R1", "still present", 32'(rom_present), 1);
  endtask

  task automatic test_read_big_fast;
    logic [19:0] a;
    a = 20'hABCDE;
    apply_reset(6, 1'b1);
    access(1'b0, a, 8'h00);
    check_latches(a, 6);
    chk("R6", "fast read width", 32'(nrd), FAST_N);
    chk("R6", "read data", 32'(got_data), 32'(rom_pat(a)));
    chk("R7", "no write on read", 32'(nwr), 0);
  endtask

  task automatic test_read_small_slow;
    logic [19:0] a;
    a = 20'hF9234;
    apply_reset(1, 1'b0);
    access(1'b0, a, 8'h00);
    check_latches(a, 1);
    chk("R6", "slow read width", 32'(nrd), SLOW_N);
    chk("R4", "aliased read data", 32'(got_data), 32'(rom_pat(20'h01234)));
    a = 20'h00FFF;
    access(1'b0, a, 8'h00);
    check_latches(a, 1);
    chk("R6", "second read data", 32'(got_data), 32'(rom_pat(a)));
  endtask

  task automatic test_write;
    logic [19:0] a;
    a = 20'hC1357;
    apply_reset(4, 1'b1);
    access(1'b1, a, 8'h5C);
    check_latches(a, 4);
    chk("R7", "write width", 32'(nwr), FAST_N);
    chk("R7", "write data driven", 32'(wr_bad), 0);
    chk("R7", "no read on write", 32'(nrd), 0);
    chk("R3", "no error when present", 32'(got_err), 0);
    apply_reset(2, 1'b0);
    access(1'b1, 20'h3FFFF, 8'hA3);
    check_latches(20'h3FFFF, 2);
    chk("R7", "slow write width", 32'(nwr), SLOW_N);
    chk("R7", "slow write data", 32'(wr_bad), 0);
  endtask

  task automatic test_absent;
    apply_reset(7, 1'b0);
    chk("R3", "mask zero", 32'(size_mask), 0);
    chk("R3", "not present", 32'(rom_present), 0);
    access(1'b0, 20'h00010, 8'h00);
    chk("R3", "read refused", 32'(got_err), 1);
    chk("R3", "no strobes on read", 32'(nlat + nrd + nwr), 0);
    access(1'b1, 20'h00020, 8'h11);
    chk("R3", "write refused", 32'(got_err), 1);
    chk("R3", "no strobes on write", 32'(nlat + nrd + nwr), 0);
    prog_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "vpp low without memory", 32'(vpp_en), 0);
    prog_req = 1'b0;
  endtask

  task automatic test_vpp;
    apply_reset(5, 1'b1);
    chk("R9", "vpp low after reset", 32'(vpp_en), 0);
    prog_req = 1'b1;
    @(negedge clk);
    chk("R9", "vpp follows request", 32'(vpp_en), 1);
    prog_req = 1'b0;
    @(negedge clk);
    chk("R9", "vpp drops", 32'(vpp_en), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    test_sizes();
    test_strap_frozen();
    test_read_big_fast();
    test_read_small_slow();
    test_write();
    test_absent();
    test_vpp();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule